// File: doc/BRIEF.md
# Per-CPU Device Interrupt Mask Unit

This block gates a shared vector of raw device interrupt requests separately for each of four CPUs. Every CPU owns a 64-bit enable mask; the bitwise AND of that mask with the raw request vector forms the CPU's masked request word. The OR of that word drives the CPU's level-1 interrupt line.

Software reaches the masks through a single-cycle 64-bit register port. Every access is accepted in the cycle it is presented; there is no back-pressure. The response (valid, error flag, read data) appears one cycle later.

On each mask write the block compares the old mask against the new one, using the raw requests sampled at that moment. It emits a one-cycle post pulse when a changed bit is now enabled and requesting. It emits a one-cycle clear pulse when a bit that was contributing to the masked request no longer does. A second, flag-selected address decode reaches the mask and masked-request arrays through a 6-bit entry field.

Top module: `cpu_irq_mask_unit`

## Requirements
- R1: A synchronous active-high `rst` clears every mask and drops every interrupt line, post pulse, clear pulse and response output.
- R2: Only 8-byte accesses are legal; `req_size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes, and any code other than 3 gives an error response.
- R3: With neither flag bit (address bits 15 and 14) set, the register index is `req_addr[13:6]`: index 0..3 is the mask of CPU 0..3 (read/write), index 4..7 is the masked request of CPU 0..3 (read-only), and index 8 is the sampled raw request vector (read-only).
- R4: A masked-request read returns that CPU's mask ANDed with the sampled raw request vector.
- R5: `dev_req` is sampled every cycle; `irq_lvl1[c]` is the OR of (mask c AND the sampled raw vector), so it follows a change of `dev_req` one cycle later as well as any mask write.
- R6: A mask write to CPU c pulses `irq_post[c]` for one cycle, in the cycle after the write, when some bit changed and is now both set in the new mask and set in the sampled raw vector.
- R7: A mask write to CPU c pulses `irq_clr[c]` for one cycle, in the cycle after the write, when some bit was set in the old masked request and is clear in the new one.
- R8: With address bit 15 set, `req_addr[9:4]` selects mask entry 0..3 for read or write.
- R9: With address bit 15 clear and bit 14 set, `req_addr[9:4]` selects the masked-request entry 0..3 for reading.
- R10: Writes to a masked-request register or to the raw request register, by either decode, give an error response.
- R11: Every access gets `resp_valid` for exactly one cycle, the cycle after it is presented. An erroring access also raises `resp_err` in that cycle, returns zero data and changes no mask. Writes return zero data.
- R12: An unmapped plain index (9 and up) or an entry field of 4 or more on either flag path gives an error response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte offset from the block base |
| req_size | input | 2 | Access size code (3 = 8 bytes) |
| req_wdata | input | 64 | Write data |
| dev_req | input | 64 | Raw device interrupt requests |
| resp_valid | output | 1 | Response strobe, one cycle after the access |
| resp_err | output | 1 | Access was illegal |
| resp_rdata | output | 64 | Read data (zero on writes and errors) |
| irq_lvl1 | output | 4 | Level-1 interrupt line per CPU |
| irq_post | output | 4 | One-cycle pulse: a mask write raised an interrupt source |
| irq_clr | output | 4 | One-cycle pulse: a mask write withdrew an interrupt source |

## Verification
The hardest case to reach from the ports is a single mask write that both posts one bit and clears another for the same CPU. A further corner of that case is a write whose bits are enabled but not requesting, which must raise neither pulse.

To reach these, the stimulus first holds a known raw pattern long enough to be sampled. It then writes masks that overlap that pattern in chosen ways: newly enabled and requesting, newly enabled but idle, dropped while requesting, and both at once. A behavioural model tracks the masks and the one-cycle-late raw sample, and every output is compared against it on every clock, including the cycles in which `dev_req` changes.

// File: rtl/cim_pkg.sv
package cim_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_MREQ = 2'd1,
    SEL_RAW  = 2'd2,
    SEL_NONE = 2'd3
  } cim_sel_e;

  localparam logic [1:0] SIZE_DWORD = 2'd3;
  localparam int         IDX_LSB    = 6;
  localparam int         ENT_LSB    = 4;
  localparam int         ENT_W      = 6;
endpackage

// File: rtl/cim_decode.sv
module cim_decode
  import cim_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_CPU = 4,
  parameter int CPU_W   = $clog2(NUM_CPU)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              write,
  output cim_sel_e          sel,
  output logic [CPU_W-1:0]  cpu,
  output logic              err
);
  localparam int ALT_MASK_BIT = ADDR_W - 1;
  localparam int ALT_REQ_BIT  = ADDR_W - 2;
  localparam int IDX_W        = ALT_REQ_BIT - IDX_LSB;

  logic [ENT_W-1:0] entry;
  logic [IDX_W-1:0] idx;

  always_comb begin
    entry = addr[ENT_LSB +: ENT_W];
    idx   = addr[ALT_REQ_BIT-1:IDX_LSB];
    sel   = SEL_NONE;
    cpu   = '0;
    if (addr[ALT_MASK_BIT]) begin
      if (int'(entry) < NUM_CPU) begin
        sel = SEL_MASK;
        cpu = entry[CPU_W-1:0];
      end
    end else if (addr[ALT_REQ_BIT]) begin
      if (int'(entry) < NUM_CPU) begin
        sel = SEL_MREQ;
        cpu = entry[CPU_W-1:0];
      end
    end else if (int'(idx) < NUM_CPU) begin
      sel = SEL_MASK;
      cpu = idx[CPU_W-1:0];
    end else if (int'(idx) < 2 * NUM_CPU) begin
      sel = SEL_MREQ;
      cpu = CPU_W'(int'(idx) - NUM_CPU);
    end else if (int'(idx) == 2 * NUM_CPU) begin
      sel = SEL_RAW;
    end
    err = (size != SIZE_DWORD) || (sel == SEL_NONE) ||
          (write && (sel != SEL_MASK));
  end
endmodule

// File: rtl/cim_mask_bank.sv
module cim_mask_bank #(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64,
  parameter int CPU_W   = $clog2(NUM_CPU)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [CPU_W-1:0]               wr_cpu,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [DATA_W-1:0]              raw,
  output logic [NUM_CPU-1:0][DATA_W-1:0] mask,
  output logic [NUM_CPU-1:0]             post,
  output logic [NUM_CPU-1:0]             clr
);
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_cpu
    logic [DATA_W-1:0] m_q;
    logic              post_q;
    logic              clr_q;
    logic              hit;
    logic [DATA_W-1:0] changed;

    assign hit     = wr_en && (wr_cpu == CPU_W'(g));
    assign changed = m_q ^ wr_data;

    always_ff @(posedge clk) begin
      if (rst) begin
        m_q    <= '0;
        post_q <= 1'b0;
        clr_q  <= 1'b0;
      end else begin
        post_q <= hit && (|(changed & wr_data & raw));
        clr_q  <= hit && (|(m_q & ~wr_data & raw));
        if (hit) m_q <= wr_data;
      end
    end

    assign mask[g] = m_q;
    assign post[g] = post_q;
    assign clr[g]  = clr_q;
  end
endmodule

// File: rtl/cim_line_gen.sv
module cim_line_gen #(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64
) (
  input  logic [NUM_CPU-1:0][DATA_W-1:0] mask,
  input  logic [DATA_W-1:0]              raw,
  output logic [NUM_CPU-1:0][DATA_W-1:0] mreq,
  output logic [NUM_CPU-1:0]             line
);
  for (genvar g = 0; g < NUM_CPU; g++) begin : g_line
    assign mreq[g] = mask[g] & raw;
    assign line[g] = |mreq[g];
  end
endmodule

// File: rtl/cpu_irq_mask_unit.sv
module cpu_irq_mask_unit
  import cim_pkg::*;
#(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64,
  parameter int ADDR_W  = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [1:0]         req_size,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [DATA_W-1:0]  dev_req,
  output logic               resp_valid,
  output logic               resp_err,
  output logic [DATA_W-1:0]  resp_rdata,
  output logic [NUM_CPU-1:0] irq_lvl1,
  output logic [NUM_CPU-1:0] irq_post,
  output logic [NUM_CPU-1:0] irq_clr
);
  localparam int CPU_W = $clog2(NUM_CPU);

  cim_sel_e                      dec_sel;
  logic [CPU_W-1:0]              dec_cpu;
  logic                          dec_err;
  logic [DATA_W-1:0]             raw_q;
  logic [NUM_CPU-1:0][DATA_W-1:0] mask_q;
  logic [NUM_CPU-1:0][DATA_W-1:0] mreq;
  logic [DATA_W-1:0]             rd_mux;
  logic                          mask_we;

  cim_decode #(.ADDR_W(ADDR_W), .NUM_CPU(NUM_CPU), .CPU_W(CPU_W)) u_dec (
    .addr  (req_addr),
    .size  (req_size),
    .write (req_write),
    .sel   (dec_sel),
    .cpu   (dec_cpu),
    .err   (dec_err)
  );

  // raw requests are sampled each cycle; no reset is needed on a pure sampler
  always_ff @(posedge clk) raw_q <= dev_req;

  assign mask_we = req_valid && req_write && !dec_err;

  cim_mask_bank #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W), .CPU_W(CPU_W)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (mask_we),
    .wr_cpu  (dec_cpu),
    .wr_data (req_wdata),
    .raw     (raw_q),
    .mask    (mask_q),
    .post    (irq_post),
    .clr     (irq_clr)
  );

  cim_line_gen #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_line (
    .mask (mask_q),
    .raw  (raw_q),
    .mreq (mreq),
    .line (irq_lvl1)
  );

  always_comb begin
    unique case (dec_sel)
      SEL_MASK: rd_mux = mask_q[dec_cpu];
      SEL_MREQ: rd_mux = mreq[dec_cpu];
      SEL_RAW:  rd_mux = raw_q;
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_rdata <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid && dec_err;
      resp_rdata <= (req_valid && !req_write && !dec_err) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/cim_checker.sv
module cim_checker #(
  parameter int NUM_CPU = 4,
  parameter int DATA_W  = 64
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           req_valid,
  input logic                           req_write,
  input logic [1:0]                     req_size,
  input logic [DATA_W-1:0]              dev_req,
  input logic                           resp_valid,
  input logic                           resp_err,
  input logic [NUM_CPU-1:0]             irq_lvl1,
  input logic [NUM_CPU-1:0]             irq_post,
  input logic [NUM_CPU-1:0]             irq_clr,
  input logic [NUM_CPU-1:0][DATA_W-1:0] mask_q
);
  AST_SHORT_ACCESS_ERR: assert property (@(posedge clk) disable iff (rst)
    req_valid && (req_size != 2'd3) |=> resp_err); // R2

  AST_REQ_GETS_RESP: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid); // R11

  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> resp_valid); // R11

  AST_ERR_KEEPS_MASKS: assert property (@(posedge clk) disable iff (rst)
    resp_err |-> (mask_q == $past(mask_q))); // R11

  for (genvar c = 0; c < NUM_CPU; c++) begin : g_chk
    AST_LINE_TRACKS_RAW: assert property (@(posedge clk) disable iff (rst)
      irq_lvl1[c] == (|(mask_q[c] & $past(dev_req)))); // R5

    AST_POST_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
      irq_post[c] |-> $past(req_valid && req_write)); // R6

    AST_CLR_AFTER_WRITE: assert property (@(posedge clk) disable iff (rst)
      irq_clr[c] |-> $past(req_valid && req_write)); // R7
  end
endmodule

bind cpu_irq_mask_unit cim_checker #(.NUM_CPU(NUM_CPU), .DATA_W(DATA_W)) u_cim_chk (
  .clk        (clk),
  .rst        (rst),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_size   (req_size),
  .dev_req    (dev_req),
  .resp_valid (resp_valid),
  .resp_err   (resp_err),
  .irq_lvl1   (irq_lvl1),
  .irq_post   (irq_post),
  .irq_clr    (irq_clr),
  .mask_q     (mask_q)
);

// File: tb/test_cpu_irq_mask_unit.sv
module test_cpu_irq_mask_unit;
  localparam int NC = 4;
  localparam int DW = 64;
  localparam int AW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr  = '0;
  logic [1:0]    req_size  = 2'd3;
  logic [DW-1:0] req_wdata = '0;
  logic [DW-1:0] dev_req   = '0;
  logic          resp_valid;
  logic          resp_err;
  logic [DW-1:0] resp_rdata;
  logic [NC-1:0] irq_lvl1;
  logic [NC-1:0] irq_post;
  logic [NC-1:0] irq_clr;

  cpu_irq_mask_unit #(.NUM_CPU(NC), .DATA_W(DW), .ADDR_W(AW)) i_cpu_irq_mask_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
    .dev_req(dev_req), .resp_valid(resp_valid), .resp_err(resp_err),
    .resp_rdata(resp_rdata), .irq_lvl1(irq_lvl1), .irq_post(irq_post),
    .irq_clr(irq_clr)
  );

  always #5 clk = ~clk;

  // behavioural reference state
  logic [DW-1:0] m_mask [NC];
  logic [DW-1:0] m_raw = '0;
  logic          e_rv = 0, e_err = 0;
  logic [DW-1:0] e_rdata = '0;
  logic [NC-1:0] e_post = '0, e_clr = '0;
  int            total = 0, bad = 0;
  string         tag = "R1";

  task automatic chk(string what, logic [DW-1:0] act, logic [DW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // kind: 0 mask, 1 masked request, 2 raw, 3 unmapped
  task automatic ref_decode(input logic [AW-1:0] a, input logic [1:0] s, input logic w,
                            output int kind, output int cpu, output bit err);
    int ent = int'(a[9:4]);
    int idx = int'(a[13:6]);
    kind = 3; cpu = 0;
    if (a[15]) begin
      if (ent < NC) begin kind = 0; cpu = ent; end
    end else if (a[14]) begin
      if (ent < NC) begin kind = 1; cpu = ent; end
    end else if (idx < NC) begin kind = 0; cpu = idx; end
    else if (idx < 2*NC) begin kind = 1; cpu = idx - NC; end
    else if (idx == 2*NC) kind = 2;
    err = (s != 2'd3) || (kind == 3) || (w && kind != 0);
  endtask

  task automatic step(bit v, bit w, logic [AW-1:0] a, logic [1:0] s, logic [DW-1:0] d);
    int kind, cpu; bit err;
    req_valid = v; req_write = w; req_addr = a; req_size = s; req_wdata = d;
    @(posedge clk);
    ref_decode(a, s, w, kind, cpu, err);
    if (rst) begin
      foreach (m_mask[i]) m_mask[i] = '0;
      e_rv = 0; e_err = 0; e_rdata = '0; e_post = '0; e_clr = '0;
    end else begin
      e_rv = v; e_err = v && err; e_rdata = '0; e_post = '0; e_clr = '0;
      if (v && !err && !w)
        e_rdata = (kind == 0) ? m_mask[cpu] : (kind == 1) ? (m_mask[cpu] & m_raw) : m_raw;
      if (v && w && !err) begin
        for (int b = 0; b < DW; b++) begin
          if (m_mask[cpu][b] != d[b] && d[b] && m_raw[b]) e_post[cpu] = 1'b1;
          if (m_mask[cpu][b] && !d[b] && m_raw[b]) e_clr[cpu] = 1'b1;
        end
        m_mask[cpu] = d;
      end
    end
    m_raw = dev_req;
    @(negedge clk);
    chk("resp_valid", resp_valid, e_rv);
    chk("resp_err", resp_err, e_err);
    chk("resp_rdata", resp_rdata, e_rdata);
    chk("irq_post", irq_post, e_post);
    chk("irq_clr", irq_clr, e_clr);
    for (int c = 0; c < NC; c++)
      chk($sformatf("irq_lvl1[%0d]", c), irq_lvl1[c], |(m_mask[c] & m_raw));
    req_valid = 0; req_write = 0;
  endtask

  task automatic idle(int n); for (int i = 0; i < n; i++) step(0, 0, '0, 2'd3, '0); endtask
  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d); step(1, 1, a, 2'd3, d); endtask
  task automatic rd(logic [AW-1:0] a); step(1, 0, a, 2'd3, '0); endtask
  function automatic logic [AW-1:0] ix(int i); return AW'(i << 6); endfunction

  initial begin
    foreach (m_mask[i]) m_mask[i] = '0;
    @(negedge clk);
    tag = "R1"; dev_req = 64'hFFFF_FFFF_FFFF_FFFF;
    idle(3);
    rst = 0;
    idle(1);
    for (int c = 0; c < NC; c++) rd(ix(c));          // R1 masks read zero

    tag = "R3";
    wr(ix(0), 64'h0000_0000_0000_00F1);
    wr(ix(1), 64'h8000_0000_0000_0000);
    wr(ix(2), 64'h0123_4567_89AB_CDEF);
    wr(ix(3), 64'h0);
    for (int c = 0; c < NC; c++) rd(ix(c));

    tag = "R5";
    dev_req = 64'h0; idle(2);
    dev_req = 64'h8000_0000_0000_0001; idle(2);
    dev_req = 64'h0000_0000_0000_0100; idle(2);

    tag = "R4";
    dev_req = 64'h00FF_0000_0000_00F0; idle(1);
    for (int c = 0; c < NC; c++) rd(ix(NC + c));
    rd(ix(2*NC));                                   // R3 raw register

    tag = "R6";
    dev_req = 64'h0000_0000_0000_000F; idle(1);
    wr(ix(3), 64'h1);                                // newly enabled and requesting
    wr(ix(3), 64'h31);                               // enabled but idle bits: no post
    tag = "R7";
    wr(ix(3), 64'h30);                               // drop requesting bit
    tag = "R6/R7";
    wr(ix(3), 64'h2);                                // post and clear together? (bit1 post only)
    wr(ix(3), 64'h4);                                // clear bit1, post bit2
    dev_req = 64'h0; wr(ix(3), 64'h8);               // raw sampled before change still 0xF
    idle(1);

    tag = "R8";
    wr(16'h8000 | 16'(2 << 4), 64'hDEAD_BEEF_0000_0001);
    rd(ix(2));
    rd(16'h8000 | 16'(1 << 4));
    tag = "R12";
    wr(16'h8000 | 16'(5 << 4), 64'h1234);
    rd(16'h8000 | 16'(63 << 4));
    rd(ix(9)); rd(ix(200));
    rd(16'h4000 | 16'(4 << 4));

    tag = "R9";
    dev_req = 64'hFFFF_0000_FFFF_0000; idle(1);
    for (int c = 0; c < NC; c++) rd(16'h4000 | 16'(c << 4));

    tag = "R10";
    wr(16'h4000 | 16'(1 << 4), 64'hFFFF);
    wr(ix(NC + 2), 64'hFFFF);
    wr(ix(2*NC), 64'hFFFF);
    for (int c = 0; c < NC; c++) rd(ix(c));          // R11 masks untouched

    tag = "R2";
    for (int s = 0; s < 3; s++) begin
      step(1, 0, ix(0), 2'(s), '0);
      step(1, 1, ix(1), 2'(s), 64'h5555);
    end
    tag = "R11";
    rd(ix(1)); idle(1);

    tag = "R1";
    rst = 1; idle(2); rst = 0; idle(1);
    for (int c = 0; c < NC; c++) rd(ix(c));

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #2_000_000;
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule